// File: doc/BRIEF.md
# Programmable Tap-Select Interval Timer

A sixteen-stage binary counter advances on every rising edge of the block clock. A two-bit time select picks which counter stage drives the single output. The four choices give periods of 2^8, 2^10, 2^13 or 2^16 clocks. For the shortest period, the counter's lowest eight stages are bypassed and the upper stages count every clock. An output polarity input sets the resting level. While the block is in reset, the output sits at that level.

The block has two operating modes. In recycle mode, the selected stage is shown continuously as a square wave. In single-cycle mode, the output changes state exactly once, after half of the selected period, and then stays frozen. A single-cycle run is restarted in one of two ways: a master reset pulse, or any change of level on the mode input. Because a master reset pulse can arrive at any time and always restarts the interval, the block works as a retriggerable one-shot. A separate power-on reset request clears the block in the same way as master reset, but only while the auto-reset input is low.

Top module: `tap_interval_timer`

## Requirements
- R1: While `mstReset` is 1, `timerOut` equals `polSel`. The clock edge seen with `mstReset` at 1 clears all counter stages and the single-cycle latch. The count after release starts from zero.
- R2: `porReq` at 1 acts exactly like `mstReset` when `autoRstOff` is 0. When `autoRstOff` is 1, `porReq` has no effect on the output or on the count.
- R3: The time select is the 2-bit code {`tsA`,`tsB`}. Code 2'b11 taps stage 16 (period 65536). Code 2'b00 taps stage 13 (period 8192). Code 2'b01 taps stage 10 (period 1024).
- R4: Code 2'b10 bypasses the lowest eight stages. Stages 9 to 16 then advance on every clock, and the stage-16 tap has a period of 256 clocks.
- R5: With `modeRun` at 1, `timerOut` is the selected stage XOR `polSel`. It is low for the first half-period after a clear and high for the second half, repeating.
- R6: With `modeRun` at 0, `timerOut` leaves its reset level in the cycle in which exactly 2^(n-1) clocks have elapsed since the clearing edge, where 2^n is the selected period.
- R7: After that change in single-cycle mode, `timerOut` holds its new level for at least 2^n further clocks, for as long as no reset or mode change occurs.
- R8: A change of level on `modeRun` clears the counter and the latch at the next clock edge. This starts a new single-cycle run that flips again 2^(n-1) clocks later.
- R9: A master reset pulse in the middle of a single-cycle interval, or after the flip, restarts the interval from zero (retrigger).
- R10: `polSel` at 1 inverts the output in every mode. The reset level is then 1, and the single-cycle flip goes to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock |
| mstReset | input | 1 | Master reset, synchronous, active high |
| porReq | input | 1 | Power-on reset request, active high |
| autoRstOff | input | 1 | 1 disables the power-on reset request |
| tsA | input | 1 | Time select, upper bit |
| tsB | input | 1 | Time select, lower bit |
| modeRun | input | 1 | 1 = recycle mode, 0 = single-cycle mode |
| polSel | input | 1 | Output polarity and reset level |
| timerOut | output | 1 | Timer output |

## Verification
The hardest case to reach from the ports is the long hold of R7 on the widest tap. The output must stay frozen for 65536 clocks after flipping on clock 32768, with no reset or mode change in that span. The stimulus runs one uninterrupted single-cycle pass per tap setting and compares every cycle against an expectation computed from the elapsed clock count. The rearm of R8 needs the mode level to change twice in consecutive cycles. The cycles where the mode input differs from its previous level are marked unchecked when their value depends on the old count. The windows that follow are then checked from a count of zero.

// File: rtl/tap_timer_pkg.sv
package tap_timer_pkg;

  // Time-select code, {upper, lower} bit
  typedef enum logic [1:0] {
    SEL_MID    = 2'b00,
    SEL_LOW    = 2'b01,
    SEL_BYPASS = 2'b10,
    SEL_HIGH   = 2'b11
  } tapSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic clrAll;   // clear every counter stage
    logic bypass;   // upper stages count on every clock
  } dpStrobe_t;

endpackage

// File: rtl/tap_timer_dp.sv
module tap_timer_dp
  import tap_timer_pkg::*;
#(
  parameter int STAGES    = 16,
  parameter int SKIP      = 8,
  parameter int MID_STAGE = 13,
  parameter int LOW_STAGE = 10
) (
  input  logic       clk,
  input  dpStrobe_t  strobe,
  input  tapSel_e    tapSel,
  output logic       tapBit
);

  localparam int UPPER = STAGES - SKIP;

  logic [SKIP-1:0]   lowCnt;
  logic [UPPER-1:0]  highCnt;
  logic              lowWrap;
  logic [STAGES-1:0] fullCnt;

  assign lowWrap = &lowCnt;
  assign fullCnt = {highCnt, lowCnt};

  // Prescaler stages: frozen while bypassed
  always_ff @(posedge clk) begin
    if (strobe.clrAll)       lowCnt <= '0;
    else if (!strobe.bypass) lowCnt <= lowCnt + 1'b1;
  end

  // Upper stages: fed by the prescaler carry or straight from the clock
  always_ff @(posedge clk) begin
    if (strobe.clrAll)                   highCnt <= '0;
    else if (strobe.bypass || lowWrap)   highCnt <= highCnt + 1'b1;
  end

  // Tap multiplexer; both upper codes read the last stage
  always_comb begin
    unique case (tapSel)
      SEL_MID:             tapBit = fullCnt[MID_STAGE-1];
      SEL_LOW:             tapBit = fullCnt[LOW_STAGE-1];
      SEL_BYPASS, SEL_HIGH: tapBit = fullCnt[STAGES-1];
      default:             tapBit = 1'b0;
    endcase
  end

endmodule

// File: rtl/tap_timer_ctrl.sv
module tap_timer_ctrl
  import tap_timer_pkg::*;
(
  input  logic       clk,
  input  logic       mstReset,
  input  logic       porReq,
  input  logic       autoRstOff,
  input  logic       tsA,
  input  logic       tsB,
  input  logic       modeRun,
  input  logic       polSel,
  input  logic       tapBit,
  output dpStrobe_t  strobe,
  output tapSel_e    tapSel,
  output logic       timerOut
);

  logic resetActive;
  logic modePrev;
  logic modeChg;
  logic doneLatch;
  logic levelRaw;

  assign resetActive = mstReset | (porReq & ~autoRstOff);
  assign tapSel      = tapSel_e'({tsA, tsB});

  // Mode-level change detector for rearm
  always_ff @(posedge clk) modePrev <= modeRun;
  assign modeChg = modeRun ^ modePrev;

  assign strobe.clrAll = resetActive | modeChg;
  assign strobe.bypass = (tapSel == SEL_BYPASS);

  // Single-cycle latch: sets on the first high tap, cleared by a restart
  always_ff @(posedge clk) begin
    if (strobe.clrAll)           doneLatch <= 1'b0;
    else if (!modeRun && tapBit) doneLatch <= 1'b1;
  end

  assign levelRaw = modeRun ? tapBit : (doneLatch | tapBit);
  assign timerOut = resetActive ? polSel : (polSel ^ levelRaw);

endmodule

// File: rtl/tap_interval_timer.sv
module tap_interval_timer
  import tap_timer_pkg::*;
#(
  parameter int STAGES    = 16,
  parameter int SKIP      = 8,
  parameter int MID_STAGE = 13,
  parameter int LOW_STAGE = 10
) (
  input  logic clk,
  input  logic mstReset,
  input  logic porReq,
  input  logic autoRstOff,
  input  logic tsA,
  input  logic tsB,
  input  logic modeRun,
  input  logic polSel,
  output logic timerOut
);

  dpStrobe_t strobe;
  tapSel_e   tapSel;
  logic      tapBit;

  tap_timer_ctrl u_ctrl (
    .clk        (clk),
    .mstReset   (mstReset),
    .porReq     (porReq),
    .autoRstOff (autoRstOff),
    .tsA        (tsA),
    .tsB        (tsB),
    .modeRun    (modeRun),
    .polSel     (polSel),
    .tapBit     (tapBit),
    .strobe     (strobe),
    .tapSel     (tapSel),
    .timerOut   (timerOut)
  );

  tap_timer_dp #(
    .STAGES    (STAGES),
    .SKIP      (SKIP),
    .MID_STAGE (MID_STAGE),
    .LOW_STAGE (LOW_STAGE)
  ) u_dp (
    .clk    (clk),
    .strobe (strobe),
    .tapSel (tapSel),
    .tapBit (tapBit)
  );

endmodule

// File: rtl/tap_timer_checker.sv
module tap_timer_checker (
  input logic clk,
  input logic mstReset,
  input logic porReq,
  input logic autoRstOff,
  input logic tsA,
  input logic tsB,
  input logic modeRun,
  input logic polSel,
  input logic timerOut
);

  logic porActive;
  logic anyReset;
  logic modeSeen;
  logic modeFlip;

  assign porActive = porReq & ~autoRstOff;
  assign anyReset  = mstReset | porActive;

  always_ff @(posedge clk) modeSeen <= modeRun;
  assign modeFlip = modeRun != modeSeen;

  // R1: master reset holds the polarity level
  p_mst_level_r1: assert property (@(posedge clk) disable iff (porActive)
    mstReset |-> timerOut == polSel);

  // R9: the cycle after a master reset edge restarts from the resting level
  p_restart_r9: assert property (@(posedge clk) disable iff (porActive)
    mstReset |=> timerOut == polSel);

  // R2: enabled power-on request holds the polarity level
  p_por_level_r2: assert property (@(posedge clk) disable iff (mstReset)
    porActive |-> timerOut == polSel);

  // R8: after a mode level change the output returns to the resting level
  p_rearm_r8: assert property (@(posedge clk) disable iff (anyReset)
    modeFlip |=> timerOut == polSel);

  // R7: once flipped in single-cycle mode the output stays flipped
  p_single_hold_r7: assert property (@(posedge clk) disable iff (anyReset)
    (!modeRun && !$past(modeRun) && $stable(polSel) && ($past(timerOut) != $past(polSel)))
      |-> timerOut != polSel);

  // R5: in recycle mode, with the taps used, no two toggles come back to back
  p_toggle_gap_r5: assert property (@(posedge clk) disable iff (anyReset)
    (modeRun && $past(modeRun) && $stable({tsA, tsB, polSel}) && (timerOut != $past(timerOut)))
      |=> ($stable(timerOut) || !$stable({tsA, tsB, polSel, modeRun})));

endmodule

bind tap_interval_timer tap_timer_checker u_chk (
  .clk        (clk),
  .mstReset   (mstReset),
  .porReq     (porReq),
  .autoRstOff (autoRstOff),
  .tsA        (tsA),
  .tsB        (tsB),
  .modeRun    (modeRun),
  .polSel     (polSel),
  .timerOut   (timerOut)
);

// File: tb/tap_interval_timer_bench.sv
module tap_interval_timer_bench;

  typedef struct {
    bit    chk;
    logic  exp;
    string tag;
  } item_t;

  logic clk = 1'b0;
  logic mstReset = 1'b1;
  logic porReq = 1'b0;
  logic autoRstOff = 1'b1;
  logic tsA = 1'b0;
  logic tsB = 1'b0;
  logic modeRun = 1'b0;
  logic polSel = 1'b0;
  logic timerOut;

  int nCmp = 0;
  int nBad = 0;
  bit finished = 0;
  item_t sbq[$];

  always #10 clk = ~clk;

  tap_interval_timer u_tap_interval_timer (
    .clk        (clk),
    .mstReset   (mstReset),
    .porReq     (porReq),
    .autoRstOff (autoRstOff),
    .tsA        (tsA),
    .tsB        (tsB),
    .modeRun    (modeRun),
    .polSel     (polSel),
    .timerOut   (timerOut)
  );

  // Monitor: pops one expectation per cycle, compares at the falling edge
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      if (it.chk) begin
        nCmp++;
        if (timerOut !== it.exp) begin
          nBad++;
          $display("FAIL %s at %0t: timerOut actual=%b expected=%b", it.tag, $time, timerOut, it.exp);
        end
      end
    end
  end

  // Driver step: expectation for the current window, then advance one clock
  task automatic step(input bit chk, input logic exp, input string tag);
    item_t it;
    it.chk = chk;
    it.exp = exp;
    it.tag = tag;
    sbq.push_back(it);
    @(posedge clk);
    #1;
  endtask

  task automatic pulseReset(input logic p);
    mstReset = 1'b1;
    step(1, p, "R1");
    mstReset = 1'b0;
  endtask

  // Single-cycle pass: flip at 2^(n-1) clocks, hold for 2^n more
  task automatic runSingle(input logic a, input logic b, input logic p, input int n, input string selTag);
    int half;
    half = 1 << (n - 1);
    modeRun = 1'b0; tsA = a; tsB = b; polSel = p;
    step(0, 1'b0, "");
    pulseReset(p);
    for (int j = 0; j <= half + (1 << n); j++) begin
      if (j <= half) step(1, p ^ (j >= half), {"R6 ", selTag});
      else           step(1, ~p, "R7");
    end
  endtask

  initial begin
    @(posedge clk);
    #1;
    // Reset level for both polarities (R1, R10)
    step(1, 1'b0, "R1");
    polSel = 1'b1;
    step(1, 1'b1, "R10");
    polSel = 1'b0;
    mstReset = 1'b0;

    // Single-cycle passes on every tap (R3, R4, R6, R7)
    runSingle(1'b1, 1'b0, 1'b0, 8,  "R4");
    runSingle(1'b0, 1'b1, 1'b1, 10, "R3 R10");
    runSingle(1'b0, 1'b0, 1'b0, 13, "R3");
    runSingle(1'b1, 1'b1, 1'b0, 16, "R3");

    // Recycle square wave, period 1024 (R5)
    modeRun = 1'b1; tsA = 1'b0; tsB = 1'b1; polSel = 1'b0;
    step(0, 1'b0, "");
    pulseReset(1'b0);
    for (int j = 0; j < 3000; j++) step(1, ((j >> 9) & 1) != 0, "R5 R3");

    // Recycle with bypass, inverted polarity (R4, R10)
    tsA = 1'b1; tsB = 1'b0; polSel = 1'b1;
    step(0, 1'b0, "");
    pulseReset(1'b1);
    for (int j = 0; j < 700; j++) step(1, ~(((j >> 7) & 1) != 0), "R4 R10");

    // Rearm by mode change (R8)
    modeRun = 1'b0; tsA = 1'b0; tsB = 1'b1; polSel = 1'b0;
    step(0, 1'b0, "");
    pulseReset(1'b0);
    for (int j = 0; j < 600; j++) step(1, j >= 512, "R6");
    modeRun = 1'b1;
    step(0, 1'b0, "");
    modeRun = 1'b0;
    step(1, 1'b0, "R8");
    for (int j = 0; j < 700; j++) step(1, j >= 512, "R8");

    // Retrigger mid-interval and after the flip (R9)
    polSel = 1'b1;
    step(0, 1'b0, "");
    pulseReset(1'b1);
    for (int j = 0; j < 300; j++) step(1, 1'b1, "R9");
    pulseReset(1'b1);
    for (int j = 0; j < 600; j++) step(1, ~(j >= 512), "R9");
    pulseReset(1'b1);
    for (int j = 0; j < 600; j++) step(1, ~(j >= 512), "R9");

    // Power-on request: ignored when disabled, acts as reset when enabled (R2)
    polSel = 1'b0; tsA = 1'b1; tsB = 1'b0;
    step(0, 1'b0, "");
    pulseReset(1'b0);
    for (int j = 0; j < 200; j++) step(1, j >= 128, "R6");
    porReq = 1'b1; autoRstOff = 1'b1;
    for (int j = 0; j < 5; j++) step(1, 1'b1, "R2");
    autoRstOff = 1'b0;
    step(1, 1'b0, "R2");
    step(1, 1'b0, "R2");
    porReq = 1'b0;
    for (int j = 0; j < 200; j++) step(1, j >= 128, "R2");
    autoRstOff = 1'b1;

    step(0, 1'b0, "");
    step(0, 1'b0, "");
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      nCmp++;
      nBad++;
      $display("FAIL watchdog (all requirements): actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

endmodule